// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received frame is kept or dropped by looking only at its 48-bit destination MAC address. The receive path presents the address together with four mode controls: accept-everything, accept-all-group-addresses, accept-broadcast, and a 2-bit hash offset selector. The block then pulses `lkp_start`. On the following clock edge it registers a keep or drop verdict and a reason code.

Two tables are held in flops. The first is a bank of 16 exact-match entries, each written as a low word and a high word. The second is a 4096-bit group hash table, written as 128 words of 32 bits. Both tables have simple write ports. A write that falls in the same cycle as a lookup affects only later lookups.

Address byte k occupies bits [8k+7:8k] of `lkp_addr`, so byte 0 (the first byte on the wire) is in bits [7:0].

Top module: `mac_dst_filter`

## Requirements
- R1: After reset, `res_valid` and `res_accept` are 0 and `res_reason` is 0. All exact entries are invalid and every hash bit is clear, so a lookup with all modes off drops the frame.
- R2: When `promisc_all` is 1, every frame is kept with reason 1.
- R3: When `promisc_group` is 1 and address bit 0 is 1 (group address), the frame is kept with reason 2. For an address with bit 0 equal to 0, `promisc_group` has no effect.
- R4: When `bcast_ok` is 1 and all 48 address bits are 1, the frame is kept with reason 3. With `bcast_ok` at 0, an all-ones address goes on to the exact and hash checks.
- R5: Entry e matches when `{hi[15:0], lo[31:0]}` equals `lkp_addr`, so that low-word bytes 0..3 compare with address bytes 0..3 and high-word bytes 0..1 with address bytes 4..5. A match counts only when bit 31 of the high word is 1. A match keeps the frame with reason 4.
- R6: The hash index is `(lkp_addr[47:32] >> s) & 0xFFF`, where s is 4, 3, 2 or 0 for `mc_offset` 0, 1, 2 or 3. If bit (index & 31) of table word (index >> 5) is 1, the frame is kept with reason 5.
- R7: The checks have a fixed priority: accept-everything first, then group-promiscuous, then broadcast, then exact match, then hash.
- R8: `res_valid` is 1 exactly in the cycle after a cycle with `lkp_start` high. `res_accept` and `res_reason` are updated only by a lookup and hold their values otherwise.
- R9: A table write in the same cycle as `lkp_start` is not seen by that lookup, and is seen by the next one.
- R10: When no check passes, the frame is dropped: `res_accept` is 0 and `res_reason` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_start | input | 1 | Lookup request pulse |
| lkp_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| promisc_all | input | 1 | Keep every frame |
| promisc_group | input | 1 | Keep every group-addressed frame |
| bcast_ok | input | 1 | Keep all-ones destination |
| mc_offset | input | 2 | Hash shift selector |
| ent_we | input | 1 | Exact-entry write strobe |
| ent_idx | input | 4 | Exact-entry index |
| ent_hi_sel | input | 1 | 1 writes the high word, 0 the low word |
| ent_wdata | input | 32 | Exact-entry write data |
| hash_we | input | 1 | Hash word write strobe |
| hash_idx | input | 7 | Hash word index |
| hash_wdata | input | 32 | Hash word write data |
| res_valid | output | 1 | Verdict strobe |
| res_accept | output | 1 | 1 keeps the frame |
| res_reason | output | 3 | 0 none, 1 all, 2 group, 3 broadcast, 4 exact, 5 hash |

## Verification
The bench programs an entry whose address has its valid bit clear and checks that it is ignored. A design that skipped the valid test would keep that frame. The bench tries every `mc_offset` value against a single set hash bit, and sends an all-ones address with broadcast on and with broadcast off, which catches a wrong shift table and a broadcast check that masks the hash path. It also stacks several passing conditions on one address to expose a reversed priority. Finally, it writes a hash word in the same cycle as a lookup, which catches a design that forwards the new table content into the current lookup.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
   localparam int MAC_W = 48;
   typedef enum logic [2:0] {
      RSN_NONE  = 3'd0,
      RSN_ALL   = 3'd1,
      RSN_GROUP = 3'd2,
      RSN_BCAST = 3'd3,
      RSN_EXACT = 3'd4,
      RSN_HASH  = 3'd5
   } reason_e;
endpackage

// File: rtl/dfl_exact_bank.sv
module dfl_exact_bank #(
   parameter int N_ENT = 16,
   parameter int W     = 32,
   parameter int IW    = $clog2(N_ENT)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [IW-1:0]           widx,
   input  logic                    whi,
   input  logic [W-1:0]            wdata,
   input  logic [dfl_pkg::MAC_W-1:0] addr,
   output logic                    hit
);
   localparam int HI_USED = dfl_pkg::MAC_W - W;
   localparam int VBIT    = W - 1;

   if (W != 32) begin : g_bad_width
      $error("dfl_exact_bank: word width must be 32");
   end

   logic [W-1:0]     lo_q [N_ENT];
   logic [W-1:0]     hi_q [N_ENT];
   logic [N_ENT-1:0] hit_vec;

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q[e] <= '0;
            hi_q[e] <= '0;
         end else if (we && widx == IW'(e)) begin
            if (whi) hi_q[e] <= wdata;
            else     lo_q[e] <= wdata;
         end
      end

      assign hit_vec[e] = hi_q[e][VBIT] && ({hi_q[e][HI_USED-1:0], lo_q[e]} == addr);

      AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (we && whi && widx == IW'(e)) |=> (hi_q[e] == $past(wdata))); // R9
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/dfl_hash_table.sv
module dfl_hash_table #(
   parameter int WORDS = 128,
   parameter int W     = 32,
   parameter int WIX   = $clog2(WORDS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [WIX-1:0] widx,
   input  logic [W-1:0]   wdata,
   input  logic [15:0]    key,
   input  logic [1:0]     sel,
   output logic           hit
);
   localparam int BW  = $clog2(W);
   localparam int IXW = WIX + BW;

   if (IXW > 16 || W != (1 << BW)) begin : g_bad_geom
      $error("dfl_hash_table: index wider than key or word not a power of two");
   end

   logic [W-1:0]   tbl_q [WORDS];
   logic [3:0]     shamt;
   logic [15:0]    shifted;
   logic [IXW-1:0] hidx;

   always_comb begin
      case (sel)
         2'd0:    shamt = 4'd4;
         2'd1:    shamt = 4'd3;
         2'd2:    shamt = 4'd2;
         default: shamt = 4'd0;
      endcase
      shifted = key >> shamt;
      hidx    = shifted[IXW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) tbl_q[i] <= '0;
      end else if (we) begin
         tbl_q[widx] <= wdata;
      end
   end

   assign hit = tbl_q[hidx[IXW-1:BW]][hidx[BW-1:0]];

   AST_HASH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (tbl_q[$past(widx)] == $past(wdata))); // R9
endmodule

// File: rtl/mac_dst_filter.sv
module mac_dst_filter #(
   parameter int N_ENT      = 16,
   parameter int HASH_WORDS = 128,
   parameter int W          = 32,
   parameter int EIW        = $clog2(N_ENT),
   parameter int HIW        = $clog2(HASH_WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lkp_start,
   input  logic [47:0]     lkp_addr,
   input  logic            promisc_all,
   input  logic            promisc_group,
   input  logic            bcast_ok,
   input  logic [1:0]      mc_offset,
   input  logic            ent_we,
   input  logic [EIW-1:0]  ent_idx,
   input  logic            ent_hi_sel,
   input  logic [W-1:0]    ent_wdata,
   input  logic            hash_we,
   input  logic [HIW-1:0]  hash_idx,
   input  logic [W-1:0]    hash_wdata,
   output logic            res_valid,
   output logic            res_accept,
   output logic [2:0]      res_reason
);
   import dfl_pkg::*;

   if (N_ENT < 1 || HASH_WORDS < 1) begin : g_bad_cfg
      $error("mac_dst_filter: table sizes must be positive");
   end

   logic    exact_hit, hash_hit, is_group, is_bcast;
   reason_e nxt_reason;
   reason_e reason_q;
   logic    valid_q, accept_q;

   dfl_exact_bank #(.N_ENT(N_ENT), .W(W)) u_exact (
      .clk(clk), .rst_n(rst_n), .we(ent_we), .widx(ent_idx), .whi(ent_hi_sel),
      .wdata(ent_wdata), .addr(lkp_addr), .hit(exact_hit));

   dfl_hash_table #(.WORDS(HASH_WORDS), .W(W)) u_hash (
      .clk(clk), .rst_n(rst_n), .we(hash_we), .widx(hash_idx), .wdata(hash_wdata),
      .key(lkp_addr[47:32]), .sel(mc_offset), .hit(hash_hit));

   assign is_group = lkp_addr[0];
   assign is_bcast = &lkp_addr;

   always_comb begin
      if (promisc_all)                   nxt_reason = RSN_ALL;
      else if (is_group && promisc_group) nxt_reason = RSN_GROUP;
      else if (bcast_ok && is_bcast)     nxt_reason = RSN_BCAST;
      else if (exact_hit)                nxt_reason = RSN_EXACT;
      else if (hash_hit)                 nxt_reason = RSN_HASH;
      else                               nxt_reason = RSN_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         accept_q <= 1'b0;
         reason_q <= RSN_NONE;
      end else begin
         valid_q <= lkp_start;
         if (lkp_start) begin
            accept_q <= (nxt_reason != RSN_NONE);
            reason_q <= nxt_reason;
         end
      end
   end

   assign res_valid  = valid_q;
   assign res_accept = accept_q;
   assign res_reason = reason_q;

   AST_START_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_start |=> res_valid); // R8
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !lkp_start |=> !res_valid); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lkp_start |=> ($stable(res_accept) && $stable(res_reason))); // R8
   AST_ALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (lkp_start && promisc_all) |=> (res_accept && res_reason == 3'd1)); // R2
   AST_GROUP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (lkp_start && !promisc_all && promisc_group && lkp_addr[0]) |=> (res_reason == 3'd2)); // R3
   AST_DROP_MEANS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_accept == (res_reason != 3'd0))); // R10
endmodule

// File: tb/sim_mac_dst_filter.sv
module sim_mac_dst_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lkp_start = 1'b0;
   logic [47:0] lkp_addr = '0;
   logic        promisc_all = 1'b0, promisc_group = 1'b0, bcast_ok = 1'b0;
   logic [1:0]  mc_offset = 2'd0;
   logic        ent_we = 1'b0, ent_hi_sel = 1'b0;
   logic [3:0]  ent_idx = '0;
   logic [31:0] ent_wdata = '0;
   logic        hash_we = 1'b0;
   logic [6:0]  hash_idx = '0;
   logic [31:0] hash_wdata = '0;
   logic        res_valid, res_accept;
   logic [2:0]  res_reason;

   int checks = 0;
   int fails  = 0;

   logic [31:0] sh_lo [16];
   logic [31:0] sh_hi [16];
   logic [31:0] sh_hash [128];
   logic [3:0]  expq [$];
   string       tagq [$];
   logic [3:0]  last_exp = 4'h0;
   bit          have_last = 1'b0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   mac_dst_filter u0 (
      .clk(clk), .rst_n(rst_n), .lkp_start(lkp_start), .lkp_addr(lkp_addr),
      .promisc_all(promisc_all), .promisc_group(promisc_group), .bcast_ok(bcast_ok),
      .mc_offset(mc_offset), .ent_we(ent_we), .ent_idx(ent_idx), .ent_hi_sel(ent_hi_sel),
      .ent_wdata(ent_wdata), .hash_we(hash_we), .hash_idx(hash_idx), .hash_wdata(hash_wdata),
      .res_valid(res_valid), .res_accept(res_accept), .res_reason(res_reason));

   function automatic int hidx(input logic [47:0] a, input logic [1:0] mo);
      int s;
      s = (mo == 2'd0) ? 4 : (mo == 2'd1) ? 3 : (mo == 2'd2) ? 2 : 0;
      return (int'(a[47:32]) >> s) & 12'hFFF;
   endfunction

   function automatic logic [3:0] model(input logic [47:0] a, input logic ua, gp, bc,
                                        input logic [1:0] mo);
      int ix;
      if (ua) return {1'b1, 3'd1};
      if (a[0] && gp) return {1'b1, 3'd2};
      if (bc && a == 48'hFFFF_FFFF_FFFF) return {1'b1, 3'd3};
      for (int e = 0; e < 16; e++)
         if (sh_hi[e][31] && {sh_hi[e][15:0], sh_lo[e]} == a) return {1'b1, 3'd4};
      ix = hidx(a, mo);
      if (sh_hash[ix >> 5][ix & 31]) return {1'b1, 3'd5};
      return 4'h0;
   endfunction

   task automatic wr_entry(input int e, input logic hi, input logic [31:0] d);
      ent_we = 1'b1; ent_idx = 4'(e); ent_hi_sel = hi; ent_wdata = d;
      @(negedge clk);
      ent_we = 1'b0;
      if (hi) sh_hi[e] = d; else sh_lo[e] = d;
   endtask

   task automatic wr_hash(input int i, input logic [31:0] d);
      hash_we = 1'b1; hash_idx = 7'(i); hash_wdata = d;
      @(negedge clk);
      hash_we = 1'b0;
      sh_hash[i] = d;
   endtask

   // drives one lookup; optional same-cycle hash write (R9)
   task automatic lookup(input string tag, input logic [47:0] a, input logic ua, gp, bc,
                         input logic [1:0] mo, input bit hw = 0, input int hi = 0,
                         input logic [31:0] hd = '0);
      lkp_addr = a; promisc_all = ua; promisc_group = gp; bcast_ok = bc; mc_offset = mo;
      lkp_start = 1'b1;
      expq.push_back(model(a, ua, gp, bc, mo));
      tagq.push_back(tag);
      if (hw) begin hash_we = 1'b1; hash_idx = 7'(hi); hash_wdata = hd; end
      @(negedge clk);
      lkp_start = 1'b0; hash_we = 1'b0;
      if (hw) sh_hash[hi] = hd;
      @(negedge clk);
   endtask

   // monitor: pops expected verdicts, also checks outputs hold between lookups
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (res_valid) begin
            checks++;
            if (expq.size() == 0) begin
               fails++;
               $display("FAIL R8: unexpected res_valid, actual 1 expected 0");
            end else begin
               logic [3:0] ex;
               string t;
               ex = expq.pop_front();
               t = tagq.pop_front();
               if ({res_accept, res_reason} != ex) begin
                  fails++;
                  $display("FAIL %s: actual accept=%0d reason=%0d expected accept=%0d reason=%0d",
                           t, res_accept, res_reason, ex[3], ex[2:0]);
               end
               last_exp = ex; have_last = 1'b1;
            end
         end else if (have_last) begin
            checks++;
            if ({res_accept, res_reason} != last_exp) begin
               fails++;
               $display("FAIL R8: hold actual %0h expected %0h", {res_accept, res_reason}, last_exp);
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) begin sh_lo[i] = '0; sh_hi[i] = '0; end
      for (int i = 0; i < 128; i++) sh_hash[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (res_valid || res_accept || res_reason != 3'd0) begin
         fails++;
         $display("FAIL R1: reset outputs actual %0b%0b%0d expected 000", res_valid, res_accept, res_reason);
      end
      lookup("R1", 48'h5544_3322_1102, 0, 0, 0, 2'd0);
      lookup("R10", 48'hFFFF_FFFF_FFFF, 0, 0, 0, 2'd3);
      // exact entries: entry 3 valid, entry 5 same shape but invalid
      wr_entry(3, 0, 32'h3322_1102);
      wr_entry(3, 1, 32'h8000_5544);
      wr_entry(5, 0, 32'hDDCC_BBAA);
      wr_entry(5, 1, 32'h0000_FFEE);
      lookup("R5", 48'h5544_3322_1102, 0, 0, 0, 2'd0);
      lookup("R5", 48'hFFEE_DDCC_BBAA, 0, 0, 0, 2'd0);
      lookup("R5", 48'h5544_3322_1103, 0, 0, 0, 2'd0);
      // hash across every offset
      for (int mo = 0; mo < 4; mo++) begin
         int ix;
         ix = hidx(48'hCDAB_0000_5E01, 2'(mo));
         wr_hash(ix >> 5, 32'(1) << (ix & 31));
         lookup("R6", 48'hCDAB_0000_5E01, 0, 0, 0, 2'(mo));
         lookup("R6", 48'hCDAB_0000_5E01, 0, 0, 0, 2'((mo + 1) % 4));
         wr_hash(ix >> 5, 32'h0);
      end
      // group promiscuous
      lookup("R3", 48'h1234_5678_9A01, 0, 1, 0, 2'd0);
      lookup("R3", 48'h1234_5678_9A02, 0, 1, 0, 2'd0);
      // broadcast with and without enable; hash bit for all-ones at offset 3
      wr_hash(127, 32'h8000_0000);
      lookup("R4", 48'hFFFF_FFFF_FFFF, 0, 0, 1, 2'd3);
      lookup("R4", 48'hFFFF_FFFF_FFFF, 0, 0, 0, 2'd3);
      // priority ladder
      lookup("R2", 48'h0000_0000_0002, 1, 0, 0, 2'd0);
      lookup("R7", 48'hFFFF_FFFF_FFFF, 1, 1, 1, 2'd3);
      lookup("R7", 48'hFFFF_FFFF_FFFF, 0, 1, 1, 2'd3);
      wr_entry(7, 0, 32'hFFFF_FFFF);
      wr_entry(7, 1, 32'h8000_FFFF);
      lookup("R7", 48'hFFFF_FFFF_FFFF, 0, 0, 0, 2'd3);
      // same-cycle write not visible, visible next time
      lookup("R9", 48'hCDAB_0000_5E01, 0, 0, 0, 2'd3, 1, hidx(48'hCDAB_0000_5E01, 2'd3) >> 5,
             32'(1) << (hidx(48'hCDAB_0000_5E01, 2'd3) & 31));
      lookup("R9", 48'hCDAB_0000_5E01, 0, 0, 0, 2'd3);
      repeat (4) @(negedge clk);
      done = 1'b1;
      if (expq.size() != 0) begin
         checks++; fails++;
         $display("FAIL R8: %0d results missing, expected 0", expq.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule